// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register front end of an I/O interrupt controller. Software selects a register by writing an 8-bit select value, then reads or writes that register 32 bits at a time through a data window. Behind the window are three kinds of register. The first is a small identity register. The second is a read-only version register. The third is a table of 64-bit redirection entries, one per interrupt pin, each reached as two 32-bit halves. A separate end-of-interrupt register forwards a vector to the end-of-interrupt logic, but only on the controller revision that supports it.

The table is stored here. Two status bits in every entry, delivery status and remote-IRR, belong to the delivery logic. That logic updates them through a narrow status port, and software writes never alter them. The one exception is that an entry written into edge mode has its remote-IRR cleared. After every table write the block pulses a service request and a clear for that pin's end-of-interrupt counter. The delivery logic reads any entry through a combinational lookup port.

Top module: `ioreg_window`

## Requirements
- R1: Only the low 8 bits of `acc_addr` take part in decode. Offset 0x00 is the select register, 0x10 is the data window and 0x40 is the end-of-interrupt register. Accesses to any other offset read 0 and write nothing.
- R2: The select register is 8 bits wide and resets to 0. Any write at offset 0x00 loads `acc_wdata[7:0]`, whatever the access size, and a read returns it zero-extended.
- R3: A data-window or end-of-interrupt access whose `acc_size` is not 4 has no effect. Such a write changes no state and raises no pulse, and such a read returns 0.
- R4: A select value s of 0x10 or more addresses table entry (s-0x10)>>1. An odd s addresses bits [63:32] of the entry and an even s addresses bits [31:0]. If the entry number is not below NUM_PINS, the access reads 0 and a write is dropped. Select values 0x03 to 0x0F also read 0.
- R5: Select 0x00 (identity) and select 0x02 (arbitration) both read the 4-bit ID in bits [27:24]. A write to select 0x00 loads the ID from `acc_wdata[27:24]`. Writes to select 0x01 and select 0x02 are ignored.
- R6: Select 0x01 reads VERSION in bits [7:0] and NUM_PINS-1 in bits [23:16], with every other bit 0. This is 0x00170020 for 24 pins at revision 0x20.
- R7: Bit 12 (delivery status) and bit 14 (remote-IRR) of an entry keep their previous values across a window write. They change only through the status port. When `upd_valid` is high with a pin below NUM_PINS, that pin's bit 12 takes `upd_dstat` and its bit 14 takes `upd_rirr`.
- R8: After a window write, if the entry's bit 15 (trigger, 1 = level) is 0, bit 14 is stored as 0.
- R9: In the cycle after an accepted table write, `svc_req` and `ctr_clr` are high for one cycle and `ctr_pin` holds the entry number. No other event raises them.
- R10: A 4-byte write at offset 0x40 raises `eoi_req` for one cycle in the next cycle, with `eoi_vec` equal to `acc_wdata[7:0]`. This happens only when VERSION is 0x20. With VERSION 0x11, `eoi_req` stays 0.
- R11: After reset every entry holds 0x0000_0000_0001_0000, which is masked (bit 16) with all other bits 0. The ID is 0 and all pulses are low.
- R12: `look_entry` always shows the full 64-bit entry selected by `look_pin`, or 0 when `look_pin` is not below NUM_PINS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access byte offset; only bits [7:0] are decoded |
| acc_size | input | 3 | Access width in bytes (1, 2, 4 or 8) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational during a read access, else 0 |
| upd_valid | input | 1 | Status bits update strobe from delivery logic |
| upd_pin | input | PIN_W | Pin whose status bits are updated |
| upd_dstat | input | 1 | New delivery status bit (bit 12) |
| upd_rirr | input | 1 | New remote-IRR bit (bit 14) |
| look_pin | input | PIN_W | Pin selected for the lookup port |
| look_entry | output | 64 | Full entry of `look_pin` |
| svc_req | output | 1 | Service scan request pulse after a table write |
| ctr_clr | output | 1 | End-of-interrupt counter clear pulse |
| ctr_pin | output | PIN_W | Pin whose counter is cleared |
| eoi_req | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec | output | 8 | Vector carried with `eoi_req` |

## Verification
The assertions assume at most one access per cycle, with `acc_addr`, `acc_size` and `acc_wdata` stable while `acc_valid` is high. They also assume the select register's value, not an in-flight select write, decides the window target. The properties tie outputs one cycle later to the decode events of the previous cycle, so a bus that changes fields mid-access would break them. The stimulus keeps to this by changing inputs only on the falling edge, holding each access for exactly one rising edge and never overlapping status-port updates with bus writes. Random select values are drawn to span both edges of the table range and the fixed registers.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  // decoded byte offsets (low 8 address bits)
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  // select values
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  // entry bit positions
  localparam int BIT_DSTAT = 12;
  localparam int BIT_RIRR  = 14;
  localparam int BIT_TRIG  = 15;
  localparam int BIT_MASK  = 16;

  localparam logic [63:0] ENTRY_RST = 64'd1 << BIT_MASK;

  localparam logic [7:0] EOI_VERSION = 8'h20;

  function automatic logic [7:0] sel_to_index(logic [7:0] sel);
    logic [7:0] diff;
    diff = sel - SEL_TBL_BASE;
    return {1'b0, diff[7:1]};
  endfunction

  function automatic logic [31:0] id_word(logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

  function automatic logic [31:0] version_word(logic [7:0] ver, int pins);
    logic [7:0] top;
    top = 8'(pins - 1);
    return {8'h00, top, 8'h00, ver};
  endfunction

  // merge a 32-bit half into an entry, keep status bits, apply edge rule
  function automatic logic [63:0] write_entry(logic [63:0] old, logic upper,
                                              logic [31:0] data,
                                              logic dstat, logic rirr);
    logic [63:0] nxt;
    nxt = upper ? {data, old[31:0]} : {old[63:32], data};
    nxt[BIT_DSTAT] = dstat;
    nxt[BIT_RIRR]  = rirr;
    if (!nxt[BIT_TRIG]) nxt[BIT_RIRR] = 1'b0;
    return nxt;
  endfunction
endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         NUM_PINS = 24,
  parameter int         PIN_W    = 5,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [7:0]        sel_q,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              win_wr,
  output logic              win_rd,
  output logic              id_wr,
  output logic              tbl_hit,
  output logic              tbl_wr,
  output logic [PIN_W-1:0]  tbl_idx,
  output logic              tbl_upper,
  output logic              eoi_fire
);
  logic [7:0] off;
  logic       full;
  logic [7:0] idx8;
  logic       unused_hi;

  assign off       = acc_addr[7:0];
  assign unused_hi = ^{1'b0, acc_addr};
  assign full      = (acc_size == 3'd4);

  assign sel_wr = acc_valid && acc_write  && (off == OFF_SEL);
  assign sel_rd = acc_valid && !acc_write && (off == OFF_SEL);
  assign win_wr = acc_valid && acc_write  && (off == OFF_WIN) && full;
  assign win_rd = acc_valid && !acc_write && (off == OFF_WIN) && full;

  assign idx8      = sel_to_index(sel_q);
  assign tbl_hit   = (sel_q >= SEL_TBL_BASE) && (int'(idx8) < NUM_PINS);
  assign tbl_idx   = idx8[PIN_W-1:0];
  assign tbl_upper = sel_q[0];
  assign tbl_wr    = win_wr && tbl_hit;
  assign id_wr     = win_wr && (sel_q == SEL_ID);

  generate
    if (VERSION == EOI_VERSION) begin : g_eoi
      assign eoi_fire = acc_valid && acc_write && (off == OFF_EOI) && full;
    end else begin : g_no_eoi
      assign eoi_fire = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ioreg_table.sv
module ioreg_table
  import ioreg_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_idx,
  input  logic             wr_upper,
  input  logic [31:0]      wr_data,
  input  logic             upd_valid,
  input  logic [PIN_W-1:0] upd_pin,
  input  logic             upd_dstat,
  input  logic             upd_rirr,
  input  logic [PIN_W-1:0] rd_idx,
  output logic [63:0]      rd_entry,
  input  logic [PIN_W-1:0] look_pin,
  output logic [63:0]      look_entry
);
  logic [63:0] ent [NUM_PINS];

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
      logic [63:0] q;
      logic        wr_hit, upd_hit, ds_now, ri_now;

      assign wr_hit  = wr_en && (wr_idx == PIN_W'(g));
      assign upd_hit = upd_valid && (upd_pin == PIN_W'(g));
      assign ds_now  = upd_hit ? upd_dstat : q[BIT_DSTAT];
      assign ri_now  = upd_hit ? upd_rirr  : q[BIT_RIRR];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= ENTRY_RST;
        end else if (wr_hit) begin
          q <= write_entry(q, wr_upper, wr_data, ds_now, ri_now);
        end else if (upd_hit) begin
          q[BIT_DSTAT] <= upd_dstat;
          q[BIT_RIRR]  <= upd_rirr;
        end
      end

      assign ent[g] = q;
    end
  endgenerate

  assign rd_entry   = (int'(rd_idx)   < NUM_PINS) ? ent[rd_idx]   : 64'h0;
  assign look_entry = (int'(look_pin) < NUM_PINS) ? ent[look_pin] : 64'h0;
endmodule

// File: rtl/ioreg_rdmux.sv
module ioreg_rdmux
  import ioreg_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic        sel_rd,
  input  logic        win_rd,
  input  logic [7:0]  sel_q,
  input  logic [3:0]  id_q,
  input  logic        tbl_hit,
  input  logic        tbl_upper,
  input  logic [63:0] tbl_entry,
  output logic [31:0] rdata
);
  always_comb begin
    rdata = 32'h0;
    if (sel_rd) begin
      rdata = {24'h0, sel_q};
    end else if (win_rd) begin
      if (tbl_hit) begin
        rdata = tbl_upper ? tbl_entry[63:32] : tbl_entry[31:0];
      end else begin
        case (sel_q)
          SEL_ID, SEL_ARB: rdata = id_word(id_q);
          SEL_VER:         rdata = version_word(VERSION, NUM_PINS);
          default:         rdata = 32'h0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import ioreg_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  localparam int        PIN_W    = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              upd_valid,
  input  logic [PIN_W-1:0]  upd_pin,
  input  logic              upd_dstat,
  input  logic              upd_rirr,
  input  logic [PIN_W-1:0]  look_pin,
  output logic [63:0]       look_entry,
  output logic              svc_req,
  output logic              ctr_clr,
  output logic [PIN_W-1:0]  ctr_pin,
  output logic              eoi_req,
  output logic [7:0]        eoi_vec
);
  logic [7:0]       sel_q;
  logic [3:0]       id_q;

  // decode events, named for the checker
  logic             sel_wr, sel_rd, win_wr, win_rd, id_wr;
  logic             tbl_hit, tbl_wr, tbl_upper, eoi_fire;
  logic [PIN_W-1:0] tbl_idx;
  logic [63:0]      tbl_entry;

  ioreg_decode #(
    .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VERSION(VERSION)
  ) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .sel_q(sel_q),
    .sel_wr(sel_wr), .sel_rd(sel_rd), .win_wr(win_wr), .win_rd(win_rd),
    .id_wr(id_wr), .tbl_hit(tbl_hit), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
    .tbl_upper(tbl_upper), .eoi_fire(eoi_fire)
  );

  ioreg_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_upper(tbl_upper), .wr_data(acc_wdata),
    .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_dstat(upd_dstat),
    .upd_rirr(upd_rirr),
    .rd_idx(tbl_idx), .rd_entry(tbl_entry),
    .look_pin(look_pin), .look_entry(look_entry)
  );

  ioreg_rdmux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rd (
    .sel_rd(sel_rd), .win_rd(win_rd), .sel_q(sel_q), .id_q(id_q),
    .tbl_hit(tbl_hit), .tbl_upper(tbl_upper), .tbl_entry(tbl_entry),
    .rdata(acc_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 8'h0;
      id_q    <= 4'h0;
      svc_req <= 1'b0;
      ctr_clr <= 1'b0;
      ctr_pin <= '0;
      eoi_req <= 1'b0;
      eoi_vec <= 8'h0;
    end else begin
      if (sel_wr) sel_q <= acc_wdata[7:0];
      if (id_wr)  id_q  <= acc_wdata[27:24];
      svc_req <= tbl_wr;
      ctr_clr <= tbl_wr;
      if (tbl_wr)   ctr_pin <= tbl_idx;
      eoi_req <= eoi_fire;
      if (eoi_fire) eoi_vec <= acc_wdata[7:0];
    end
  end
endmodule

// File: rtl/ioreg_window_chk.sv
module ioreg_window_chk #(
  parameter int PIN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [2:0]       acc_size,
  input logic [31:0]      acc_wdata,
  input logic [31:0]      acc_rdata,
  input logic [7:0]       sel_q,
  input logic             sel_wr,
  input logic             win_rd,
  input logic             tbl_hit,
  input logic             tbl_wr,
  input logic [PIN_W-1:0] tbl_idx,
  input logic             eoi_fire,
  input logic             svc_req,
  input logic             ctr_clr,
  input logic [PIN_W-1:0] ctr_pin,
  input logic             eoi_req,
  input logic [7:0]       eoi_vec
);
  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(acc_wdata[7:0]));

  // R3
  narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size != 3'd4) |=> (!svc_req && !eoi_req));

  // R4
  oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && !tbl_hit && sel_q >= 8'h10) |-> acc_rdata == 32'h0);

  // R9
  svc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> (svc_req && ctr_clr && ctr_pin == $past(tbl_idx)));

  // R9
  svc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(tbl_wr));

  // R10
  eoi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> (eoi_req && eoi_vec == $past(acc_wdata[7:0])));
endmodule

bind ioreg_window ioreg_window_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .sel_q(sel_q), .sel_wr(sel_wr), .win_rd(win_rd), .tbl_hit(tbl_hit),
  .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .eoi_fire(eoi_fire),
  .svc_req(svc_req), .ctr_clr(ctr_clr), .ctr_pin(ctr_pin),
  .eoi_req(eoi_req), .eoi_vec(eoi_vec)
);

// File: tb/tb_ioreg_window.sv
`timescale 1ns/1ps
module tb_ioreg_window;
  localparam int NP = 24;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid, acc_write;
  logic [11:0]   acc_addr;
  logic [2:0]    acc_size;
  logic [31:0]   acc_wdata;
  logic          upd_valid, upd_dstat, upd_rirr;
  logic [PW-1:0] upd_pin, look_pin;

  logic [31:0]   rdata, rdata11;
  logic [63:0]   look, look11;
  logic          svc, svc11, clr, clr11, eoi, eoi11;
  logic [PW-1:0] cpin, cpin11;
  logic [7:0]    vec, vec11;

  always #2.5 clk = ~clk;

  ioreg_window #(.ADDR_W(12), .NUM_PINS(NP), .VERSION(8'h20)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(rdata), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_dstat(upd_dstat), .upd_rirr(upd_rirr), .look_pin(look_pin),
    .look_entry(look), .svc_req(svc), .ctr_clr(clr), .ctr_pin(cpin),
    .eoi_req(eoi), .eoi_vec(vec));

  ioreg_window #(.ADDR_W(12), .NUM_PINS(NP), .VERSION(8'h11)) dut11 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(rdata11), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_dstat(upd_dstat), .upd_rirr(upd_rirr), .look_pin(look_pin),
    .look_entry(look11), .svc_req(svc11), .ctr_clr(clr11), .ctr_pin(cpin11),
    .eoi_req(eoi11), .eoi_vec(vec11));

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [63:0] m_tbl [NP];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_read(input logic [11:0] a, input logic [2:0] sz,
                                         input logic [7:0] ver);
    int idx;
    if (a[7:0] == 8'h00) return {24'h0, m_sel};
    if (a[7:0] != 8'h10 || sz != 3'd4) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, ver};
    if (m_sel < 8'h10) return 32'h0;
    idx = (int'(m_sel) - 16) / 2;
    if (idx >= NP) return 32'h0;
    return m_sel[0] ? m_tbl[idx][63:32] : m_tbl[idx][31:0];
  endfunction

  task automatic do_write(input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] d, input string req);
    bit exp_svc = 0;
    bit exp_eoi = 0;
    int pin = 0;
    logic [63:0] nw;
    if (a[7:0] == 8'h10 && sz == 3'd4) begin
      if (m_sel == 8'h00) m_id = d[27:24];
      else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < NP) begin
        pin = (int'(m_sel) - 16) / 2;
        nw  = m_sel[0] ? {d, m_tbl[pin][31:0]} : {m_tbl[pin][63:32], d};
        nw  = (nw & ~64'h5000) | (m_tbl[pin] & 64'h5000);
        if (nw[15] == 1'b0) nw[14] = 1'b0;
        m_tbl[pin] = nw;
        exp_svc = 1;
      end
    end
    if (a[7:0] == 8'h40 && sz == 3'd4) exp_eoi = 1;
    if (a[7:0] == 8'h00) m_sel = d[7:0];
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk({req, " R9 svc_req"}, 64'(svc), 64'(exp_svc));
    chk({req, " R9 ctr_clr"}, 64'(clr), 64'(exp_svc));
    if (exp_svc) chk({req, " R9 ctr_pin"}, 64'(cpin), 64'(pin));
    chk({req, " R10 eoi_req"}, 64'(eoi), 64'(exp_eoi));
    if (exp_eoi) chk({req, " R10 eoi_vec"}, 64'(vec), 64'(d[7:0]));
    chk({req, " R10 rev11 eoi_req"}, 64'(eoi11), 64'h0);
  endtask

  task automatic do_read(input logic [11:0] a, input logic [2:0] sz, input string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
    #1;
    chk({req, " read"}, 64'(rdata), 64'(f_read(a, sz, 8'h20)));
    chk({req, " read rev11"}, 64'(rdata11), 64'(f_read(a, sz, 8'h11)));
    acc_valid = 0;
  endtask

  task automatic do_upd(input int pin, input bit ds, input bit ri);
    @(negedge clk);
    upd_valid = 1; upd_pin = PW'(pin); upd_dstat = ds; upd_rirr = ri;
    @(negedge clk);
    upd_valid = 0;
    if (pin < NP) begin
      m_tbl[pin][12] = ds;
      m_tbl[pin][14] = ri;
    end
  endtask

  task automatic do_look(input int pin, input string req);
    look_pin = PW'(pin);
    #1;
    chk({req, " look_entry"}, look, (pin < NP) ? m_tbl[pin] : 64'h0);
  endtask

  function automatic logic [2:0] pick_size();
    int r;
    r = $urandom_range(0, 7);
    if (r == 0) return 3'd2;
    if (r == 1) return 3'd1;
    if (r == 2) return 3'd8;
    return 3'd4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_addr = '0; acc_size = 3'd4;
    acc_wdata = '0; upd_valid = 0; upd_pin = '0; upd_dstat = 0; upd_rirr = 0;
    look_pin = '0;
    m_sel = 8'h0; m_id = 4'h0;
    for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    chk("R11 svc_req idle", 64'(svc), 64'h0);
    chk("R11 eoi_req idle", 64'(eoi), 64'h0);
    do_read(12'h000, 3'd4, "R11 R2 select reset");
    do_read(12'h010, 3'd4, "R11 R5 id reset");
    do_look(0, "R11 entry0");
    do_look(NP - 1, "R11 last entry R12");

    // R2 select load, any size
    do_write(12'h000, 3'd1, 32'hFFFF_FF23, "R2 sel");
    do_read(12'h000, 3'd2, "R2 sel readback");

    // R1 aliasing of upper address bits, R6 version
    do_write(12'h300, 3'd4, 32'h0000_0001, "R1 sel alias");
    do_read(12'hF10, 3'd4, "R1 R6 version");

    // R5 id and arbitration
    do_write(12'h000, 3'd4, 32'h0, "R5 sel id");
    do_write(12'h010, 3'd4, 32'hFA00_0000, "R5 id write");
    do_read(12'h010, 3'd4, "R5 id read");
    do_write(12'h000, 3'd4, 32'h2, "R5 sel arb");
    do_write(12'h010, 3'd4, 32'h0500_0000, "R5 arb write ignored");
    do_read(12'h010, 3'd4, "R5 arb read");
    do_write(12'h000, 3'd4, 32'h1, "R5 sel ver");
    do_write(12'h010, 3'd4, 32'hFFFF_FFFF, "R5 ver write ignored");
    do_read(12'h010, 3'd4, "R5 R6 ver after write");

    // R4 R7 table halves, pin 5
    do_write(12'h000, 3'd4, 32'h1A, "R4 sel pin5 low");
    do_write(12'h010, 3'd4, 32'h0000_C0A5, "R7 low write");
    do_read(12'h010, 3'd4, "R7 low read");
    do_write(12'h000, 3'd4, 32'h1B, "R4 sel pin5 high");
    do_write(12'h010, 3'd4, 32'hFF00_0000, "R4 high write");
    do_read(12'h010, 3'd4, "R4 high read");
    do_look(5, "R4 R12 pin5");

    // R7 status port, then window write keeps it
    do_upd(5, 1, 1);
    do_look(5, "R7 status update");
    do_write(12'h000, 3'd4, 32'h1A, "R7 sel");
    do_write(12'h010, 3'd4, 32'h0000_8033, "R7 level write");
    do_look(5, "R7 status kept");

    // R8 edge write clears remote-IRR
    do_write(12'h010, 3'd4, 32'h0000_0033, "R8 edge write");
    do_look(5, "R8 rirr cleared");
    do_read(12'h010, 3'd4, "R8 read");

    // R4 out of range
    do_write(12'h000, 3'd4, 32'h40, "R4 sel oob");
    do_read(12'h010, 3'd4, "R4 oob read");
    do_write(12'h010, 3'd4, 32'hFFFF_FFFF, "R4 oob write");
    do_write(12'h000, 3'd4, 32'h05, "R4 sel gap");
    do_read(12'h010, 3'd4, "R4 gap read");
    do_write(12'h000, 3'd4, 32'h3F, "R4 sel last high");
    do_read(12'h010, 3'd4, "R4 last high read");
    do_upd(30, 1, 1);
    do_look(30, "R12 oob look");

    // R3 narrow accesses
    do_write(12'h000, 3'd4, 32'h10, "R3 sel");
    do_write(12'h010, 3'd2, 32'h0000_FFFF, "R3 narrow window write");
    do_read(12'h010, 3'd2, "R3 narrow read");
    do_look(0, "R3 entry0 unchanged");
    do_write(12'h040, 3'd1, 32'h77, "R3 narrow eoi");

    // R10 eoi
    do_write(12'h040, 3'd4, 32'h1234_56AB, "R10 eoi");
    do_write(12'hA40, 3'd4, 32'h0000_0031, "R10 R1 eoi alias");

    // R1 unmapped offset
    do_write(12'h020, 3'd4, 32'hFFFF_FFFF, "R1 unmapped write");
    do_read(12'h020, 3'd4, "R1 unmapped read");

    // random phase
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: do_write(12'h000, 3'd4, 32'($urandom_range(0, 8'h45)), "R2 rnd sel");
        2, 3, 4: do_write({4'($urandom_range(0, 15)), 8'h10}, pick_size(),
                          $urandom(), "R4 R7 R8 rnd write");
        5, 6: do_read({4'($urandom_range(0, 15)), 8'h10}, pick_size(), "R4 R5 rnd read");
        7: do_upd($urandom_range(0, 31), 1'($urandom()), 1'($urandom()));
        8: do_look($urandom_range(0, 31), "R7 R8 R12 rnd look");
        default: do_write(12'h040, pick_size(), $urandom(), "R10 R3 rnd eoi");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule